// File: doc/BRIEF.md
# Circular Receive Queue Bound Register Bank

This block keeps the pointer state for a set of receive queues, each laid out as a ring of fixed-size entries in memory. Every queue has a programmable base address (its lower bound) and its own head pointer, tail pointer and occupancy count. A per-queue size code sets the ring length. The upper bound follows from the base and the size. An enqueue pulse moves the tail forward and a dequeue pulse moves the head forward. Each pointer returns to the base once it has passed the last entry of the ring.

Software reaches the bank over a simple register bus with read and write strobes. The bank holds four read slots per queue: base, head, tail and status. Only the base slot can be written. Writes land only while the diagnostic-mode input is high, and a write to a base restarts that queue. The base is kept 1 KB aligned. It holds a full 64-bit address only when the queue is configured for wide system memory addressing. Otherwise it holds 32 bits.

Top module: `rxq_bound_bank`

## Requirements
- R1: Queue n is decoded at byte address 0x1800 + n*0x40, with n running from 0 to 15. Within a queue, offset 0x00 reads the base, 0x08 reads the head, 0x10 reads the tail and 0x18 reads the status word, which carries the length in bits [10:0] and the error flag in bit 16. Every other address reads as zero. Read data appears on `rdata` in the cycle after `rd_en` is sampled, and it holds until the next read.
- R2: An accepted write to a queue's base slot sets that queue's head and tail to the new base, clears its length to zero and clears its error flag.
- R3: Head and tail each advance by 8 bytes per accepted operation. A pointer that sits on the last entry (base + size - 8) moves back to the base. The size is 1 KB, 2 KB, 4 KB or 8 KB for size codes 0, 1, 2 and 3.
- R4: Bits [9:0] of every base register read as zero, whatever data was written.
- R5: A write while `diag_en` is low changes no register.
- R6: A base register is 64 bits wide only when all three of these hold: the queue's `sysq_flag` bit is 1, its `mem_sel` field is 2'b01, and `master64_en` is 1. Otherwise bits [63:32] are stored as zero and read as zero.
- R7: After reset every base, head, tail, length and error flag is zero.
- R8: An enqueue when the length equals the capacity (size/8), or a dequeue when the length is zero, is ignored and sets that queue's sticky error flag.
- R9: Each accepted enqueue adds one to the length and each accepted dequeue subtracts one. When both are accepted in the same cycle the length stays the same and both pointers advance.
- R10: When a base write and an enqueue or dequeue reach the same queue in the same cycle, the write takes effect and the pointer and length update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| diag_en | input | 1 | Diagnostic mode; base writes take effect only while it is high |
| master64_en | input | 1 | Global enable for 64-bit master addressing |
| sysq_flag | input | NQ | Per-queue system receive-queue flag |
| mem_sel | input | 2*NQ | Per-queue memory select; 2'b01 selects wide system memory |
| size_code | input | 2*NQ | Per-queue ring size code (0:1 KB .. 3:8 KB) |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 64 | Register write data |
| rdata | output | 64 | Registered read data |
| enq | input | NQ | Per-queue enqueue pulse |
| deq | input | NQ | Per-queue dequeue pulse |
| q_err | output | NQ | Per-queue sticky overflow/underflow flag |

## Verification
The hardest point to reach from the ports is the wrap and full boundary. A ring must be filled entry by entry until the tail sits exactly on the last slot, and the next enqueue must then land on the base and not on the address that follows. The stimulus holds one enqueue pulse high for a counted run of cycles on a 1 KB ring. It reads the tail one entry short of the wrap and again after the wrap. It then pushes once more to raise the overflow flag, and drains the ring fully to check the head wrap and the underflow case. The second awkward case is a base write and an enqueue on the same queue in the same clock. This takes a hand-built cycle in which both strobes are driven together.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int PTR_W = 64;

   typedef logic [PTR_W-1:0] ptr_t;

   typedef enum logic [1:0] {
      SLOT_BASE = 2'd0,
      SLOT_HEAD = 2'd1,
      SLOT_TAIL = 2'd2,
      SLOT_STAT = 2'd3
   } slot_e;

   localparam logic [1:0] MEMSEL_WIDE = 2'b01;
   localparam int         STAT_ERR_BIT = 16;

endpackage

// File: rtl/rxq_addr_dec.sv
module rxq_addr_dec
   import rxq_pkg::*;
#(
   parameter int              NQ         = 16,
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h1800,
   parameter int              STRIDE_LG2 = 6,
   localparam int             QW         = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [QW-1:0]     q_idx,
   output slot_e             slot
);

   localparam logic [ADDR_W:0] WIN_LO = {1'b0, REG_BASE};
   localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(NQ << STRIDE_LG2);

   logic [ADDR_W-1:0] offs;
   logic              in_win;
   logic              slot_ok;

   assign offs    = addr - REG_BASE;
   assign in_win  = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
   assign slot_ok = (offs[2:0] == 3'b000) && (offs[STRIDE_LG2-1:5] == '0);
   assign hit     = in_win && slot_ok;
   assign q_idx   = offs[STRIDE_LG2 +: QW];
   assign slot    = slot_e'(offs[4:3]);

endmodule

// File: rtl/rxq_queue.sv
module rxq_queue
   import rxq_pkg::*;
#(
   parameter int ENTRY_BYTES  = 8,
   parameter int MIN_SIZE_LG2 = 10,
   parameter int LEN_W        = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       base_wr,
   input  ptr_t       base_wdata,
   input  logic [1:0] size_code,
   input  logic       enq,
   input  logic       deq,
   output ptr_t       base,
   output ptr_t       head,
   output ptr_t       tail,
   output logic [LEN_W-1:0] len,
   output logic       err
);

   localparam int ENTRY_LG2 = $clog2(ENTRY_BYTES);

   ptr_t             size_b;
   ptr_t             upper;
   logic [LEN_W-1:0] cap;
   logic             enq_ok;
   logic             deq_ok;
   logic             bad_op;

   assign size_b = PTR_W'(1) << (MIN_SIZE_LG2 + int'(size_code));
   assign upper  = base + size_b - PTR_W'(ENTRY_BYTES);
   assign cap    = LEN_W'(size_b >> ENTRY_LG2);
   assign enq_ok = enq && (len < cap);
   assign deq_ok = deq && (len != '0);
   assign bad_op = (enq && !enq_ok) || (deq && !deq_ok);

   function automatic ptr_t step(input ptr_t p, input ptr_t lo, input ptr_t hi);
      return (p >= hi) ? lo : p + PTR_W'(ENTRY_BYTES);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         head <= '0;
         tail <= '0;
         len  <= '0;
         err  <= 1'b0;
      end else if (base_wr) begin
         base <= base_wdata;
         head <= base_wdata;
         tail <= base_wdata;
         len  <= '0;
         err  <= 1'b0;
      end else begin
         if (enq_ok) tail <= step(tail, base, upper);
         if (deq_ok) head <= step(head, base, upper);
         case ({enq_ok, deq_ok})
            2'b10:   len <= len + 1'b1;
            2'b01:   len <= len - 1'b1;
            default: len <= len;
         endcase
         if (bad_op) err <= 1'b1;
      end
   end

endmodule

// File: rtl/rxq_bound_bank.sv
module rxq_bound_bank
   import rxq_pkg::*;
#(
   parameter int              NQ           = 16,
   parameter int              ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] REG_BASE   = 16'h1800,
   parameter int              STRIDE_LG2   = 6,
   parameter int              ENTRY_BYTES  = 8,
   parameter int              MIN_SIZE_LG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              diag_en,
   input  logic              master64_en,
   input  logic [NQ-1:0]     sysq_flag,
   input  logic [2*NQ-1:0]   mem_sel,
   input  logic [2*NQ-1:0]   size_code,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   output logic [63:0]       rdata,
   input  logic [NQ-1:0]     enq,
   input  logic [NQ-1:0]     deq,
   output logic [NQ-1:0]     q_err
);

   localparam int QW        = (NQ > 1) ? $clog2(NQ) : 1;
   localparam int ALIGN_LG2 = MIN_SIZE_LG2;
   localparam int MAX_ENTR  = (1 << (MIN_SIZE_LG2 + 3)) / ENTRY_BYTES;
   localparam int LEN_W     = $clog2(MAX_ENTR + 1);

   // elaboration-time parameter checks
   if (STRIDE_LG2 < 6) begin : g_bad_stride
      $error("STRIDE_LG2 must leave room for four 8-byte slots");
   end
   if (LEN_W > STAT_ERR_BIT) begin : g_bad_len
      $error("length field overlaps the error bit in the status word");
   end
   if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0 || ENTRY_BYTES < 8) begin : g_bad_entry
      $error("ENTRY_BYTES must be a power of two of at least 8");
   end
   if (ALIGN_LG2 < 3 || ALIGN_LG2 > 31) begin : g_bad_align
      $error("alignment must fall within the low word");
   end

   logic             dec_hit;
   logic [QW-1:0]    dec_q;
   slot_e            dec_slot;
   logic             wr_acc;
   logic [NQ-1:0]    wide;
   logic [NQ-1:0]    base_wr;
   ptr_t [NQ-1:0]    q_base;
   ptr_t [NQ-1:0]    q_head;
   ptr_t [NQ-1:0]    q_tail;
   logic [NQ-1:0][LEN_W-1:0] q_len;
   logic [63:0]      rd_val;
   logic             unused_wlow;

   assign unused_wlow = ^wdata[ALIGN_LG2-1:0];

   rxq_addr_dec #(
      .NQ(NQ), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .STRIDE_LG2(STRIDE_LG2)
   ) u_dec (
      .addr(addr), .hit(dec_hit), .q_idx(dec_q), .slot(dec_slot)
   );

   assign wr_acc = wr_en && diag_en && dec_hit && (dec_slot == SLOT_BASE);

   for (genvar g = 0; g < NQ; g++) begin : g_q
      ptr_t wmask;

      assign wide[g]    = sysq_flag[g] && (mem_sel[2*g +: 2] == MEMSEL_WIDE) && master64_en;
      assign base_wr[g] = wr_acc && (dec_q == QW'(g));
      assign wmask      = {wide[g] ? wdata[63:32] : 32'h0,
                           wdata[31:ALIGN_LG2], {ALIGN_LG2{1'b0}}};

      rxq_queue #(
         .ENTRY_BYTES(ENTRY_BYTES), .MIN_SIZE_LG2(MIN_SIZE_LG2), .LEN_W(LEN_W)
      ) u_q (
         .clk(clk), .rst_n(rst_n),
         .base_wr(base_wr[g]), .base_wdata(wmask),
         .size_code(size_code[2*g +: 2]),
         .enq(enq[g]), .deq(deq[g]),
         .base(q_base[g]), .head(q_head[g]), .tail(q_tail[g]),
         .len(q_len[g]), .err(q_err[g])
      );
   end

   always_comb begin
      rd_val = '0;
      case (dec_slot)
         SLOT_BASE: rd_val = wide[dec_q] ? q_base[dec_q] : {32'h0, q_base[dec_q][31:0]};
         SLOT_HEAD: rd_val = q_head[dec_q];
         SLOT_TAIL: rd_val = q_tail[dec_q];
         default: begin
            rd_val[LEN_W-1:0]    = q_len[dec_q];
            rd_val[STAT_ERR_BIT] = q_err[dec_q];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= dec_hit ? rd_val : 64'h0;
   end

endmodule

// File: rtl/rxq_bound_chk.sv
module rxq_bound_chk #(
   parameter int              NQ           = 16,
   parameter int              ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] REG_BASE   = 16'h1800,
   parameter int              STRIDE_LG2   = 6,
   parameter int              ENTRY_BYTES  = 8,
   parameter int              MIN_SIZE_LG2 = 10,
   parameter int              LEN_W        = 11
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     diag_en,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        addr,
   input logic [2*NQ-1:0]          size_code,
   input logic [NQ-1:0]            enq,
   input logic [NQ-1:0]            deq,
   input logic [NQ-1:0][63:0]      q_base,
   input logic [NQ-1:0][63:0]      q_head,
   input logic [NQ-1:0][63:0]      q_tail,
   input logic [NQ-1:0][LEN_W-1:0] q_len,
   input logic [NQ-1:0]            q_err
);

   localparam int CAP_MIN = (1 << MIN_SIZE_LG2) / ENTRY_BYTES;

   for (genvar q = 0; q < NQ; q++) begin : g_chk
      logic             hit_w;
      logic [LEN_W:0]   cap;

      assign hit_w = wr_en && diag_en && (addr == ADDR_W'(int'(REG_BASE) + (q << STRIDE_LG2)));
      assign cap   = (LEN_W+1)'(CAP_MIN) << size_code[2*q +: 2];

      // R2 and R10: a base write restarts the queue, whatever else arrives
      a_r2_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
         hit_w |=> (q_head[q] == q_base[q]) && (q_tail[q] == q_base[q]) &&
                   (q_len[q] == '0) && !q_err[q]);

      a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
         q_base[q][MIN_SIZE_LG2-1:0] == '0);

      a_r5_locked_outside_diag: assert property (@(posedge clk) disable iff (!rst_n)
         !diag_en |=> $stable(q_base[q]));

      a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (q_err[q] && !hit_w) |=> q_err[q]);

      a_r8_len_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
         {1'b0, q_len[q]} <= cap);

      a_r9_len_held_on_both: assert property (@(posedge clk) disable iff (!rst_n)
         (enq[q] && deq[q] && !hit_w && q_len[q] != '0 && {1'b0, q_len[q]} < cap)
         |=> $stable(q_len[q]));

      a_r3_tail_moves_on_enq: assert property (@(posedge clk) disable iff (!rst_n)
         (enq[q] && !deq[q] && !hit_w && {1'b0, q_len[q]} < cap)
         |=> (q_tail[q] != $past(q_tail[q])));
   end

endmodule

bind rxq_bound_bank rxq_bound_chk #(
   .NQ(NQ), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .STRIDE_LG2(STRIDE_LG2),
   .ENTRY_BYTES(ENTRY_BYTES), .MIN_SIZE_LG2(MIN_SIZE_LG2), .LEN_W(LEN_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .wr_en(wr_en), .addr(addr),
   .size_code(size_code), .enq(enq), .deq(deq),
   .q_base(q_base), .q_head(q_head), .q_tail(q_tail), .q_len(q_len), .q_err(q_err)
);

// File: tb/rxq_bound_bank_tb_top.sv
module rxq_bound_bank_tb_top;

   localparam int NQ = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          diag_en = 1'b0;
   logic          master64_en = 1'b1;
   logic [NQ-1:0] sysq_flag = '0;
   logic [2*NQ-1:0] mem_sel = {NQ{2'b01}};
   logic [2*NQ-1:0] size_code = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [15:0]   addr = '0;
   logic [63:0]   wdata = '0;
   logic [63:0]   rdata;
   logic [NQ-1:0] enq = '0;
   logic [NQ-1:0] deq = '0;
   logic [NQ-1:0] q_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rxq_bound_bank dut_i (
      .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .master64_en(master64_en),
      .sysq_flag(sysq_flag), .mem_sel(mem_sel), .size_code(size_code),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .enq(enq), .deq(deq), .q_err(q_err)
   );

   function automatic logic [15:0] qa(input int q, input int slot);
      return 16'(16'h1800 + q * 16'h40 + slot * 8);
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [15:0] a, output logic [63:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ops(input int q, input bit e, input bit d, input int n);
      @(negedge clk);
      enq[q] = e; deq[q] = d;
      repeat (n) @(negedge clk);
      enq[q] = 1'b0; deq[q] = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      rd(qa(0, 0), d);  check("R7 base q0", d, 64'h0);
      rd(qa(15, 1), d); check("R7 head q15", d, 64'h0);
      rd(qa(7, 3), d);  check("R7 status q7", d, 64'h0);
      check("R7 err flags", 64'(q_err), 64'h0);
   endtask

   task automatic t_locked();
      logic [63:0] d;
      diag_en = 1'b0;
      wr(qa(3, 0), 64'h0000_0000_0001_0000);
      rd(qa(3, 0), d); check("R5 write ignored outside diag", d, 64'h0);
      diag_en = 1'b1;
   endtask

   task automatic t_width();
      logic [63:0] d;
      wr(qa(3, 0), 64'h1234_5678_9ABC_DEF0);
      rd(qa(3, 0), d); check("R6 narrow base, R4 low bits", d, 64'h0000_0000_9ABC_DC00);
      sysq_flag[3] = 1'b1;
      wr(qa(3, 0), 64'h1234_5678_9ABC_DEF0);
      rd(qa(3, 0), d); check("R6 wide base", d, 64'h1234_5678_9ABC_DC00);
      rd(qa(3, 1), d); check("R2 head set to base", d, 64'h1234_5678_9ABC_DC00);
      rd(qa(3, 2), d); check("R2 tail set to base", d, 64'h1234_5678_9ABC_DC00);
      master64_en = 1'b0;
      rd(qa(3, 0), d); check("R6 upper word reads zero when narrow", d, 64'h0000_0000_9ABC_DC00);
      master64_en = 1'b1;
      mem_sel[7:6] = 2'b10;
      rd(qa(3, 0), d); check("R6 other mem_sel is narrow", d, 64'h0000_0000_9ABC_DC00);
      mem_sel[7:6] = 2'b01;
   endtask

   task automatic t_fifo();
      logic [63:0] d;
      wr(qa(5, 0), 64'h4000);
      ops(5, 1, 0, 3);
      rd(qa(5, 3), d); check("R9 length after 3 enq", d, 64'd3);
      rd(qa(5, 2), d); check("R3 tail after 3 enq", d, 64'h4018);
      ops(5, 0, 1, 1);
      rd(qa(5, 3), d); check("R9 length after deq", d, 64'd2);
      rd(qa(5, 1), d); check("R3 head after deq", d, 64'h4008);
      ops(5, 1, 1, 1);
      rd(qa(5, 3), d); check("R9 length held on enq+deq", d, 64'd2);
      rd(qa(5, 1), d); check("R9 head moved on enq+deq", d, 64'h4010);
      rd(qa(5, 2), d); check("R9 tail moved on enq+deq", d, 64'h4020);
   endtask

   task automatic t_wrap();
      logic [63:0] d;
      wr(qa(6, 0), 64'h8000);
      ops(6, 1, 0, 127);
      rd(qa(6, 2), d); check("R3 tail on last entry", d, 64'h83F8);
      ops(6, 1, 0, 1);
      rd(qa(6, 2), d); check("R3 tail wraps to base", d, 64'h8000);
      rd(qa(6, 3), d); check("R9 full length", d, 64'd128);
      ops(6, 1, 0, 1);
      rd(qa(6, 3), d); check("R8 overflow sets err, length kept", d, 64'h1_0080);
      rd(qa(6, 2), d); check("R8 overflow leaves tail", d, 64'h8000);
      check("R8 err port", 64'(q_err[6]), 64'd1);
      ops(6, 0, 1, 128);
      rd(qa(6, 1), d); check("R3 head wraps to base", d, 64'h8000);
      rd(qa(6, 3), d); check("R8 err sticky after drain", d, 64'h1_0000);
      ops(6, 0, 1, 1);
      rd(qa(6, 1), d); check("R8 underflow leaves head", d, 64'h8000);
      rd(qa(6, 3), d); check("R8 underflow length zero", d, 64'h1_0000);
      wr(qa(6, 0), 64'h8400);
      rd(qa(6, 3), d); check("R2 base write clears status", d, 64'h0);
      rd(qa(6, 1), d); check("R2 head to new base", d, 64'h8400);
   endtask

   task automatic t_collide();
      logic [63:0] d;
      ops(6, 1, 0, 2);
      @(negedge clk);
      wr_en = 1'b1; addr = qa(6, 0); wdata = 64'h8800; enq[6] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; enq[6] = 1'b0;
      rd(qa(6, 3), d); check("R10 write wins, length zero", d, 64'h0);
      rd(qa(6, 2), d); check("R10 tail at new base", d, 64'h8800);
   endtask

   task automatic t_decode();
      logic [63:0] d;
      wr(16'h1BC0, 64'h0C00);
      rd(qa(15, 0), d);  check("R1 last queue at 0x1BC0", d, 64'h0C00);
      rd(qa(14, 0), d);  check("R1 neighbour untouched", d, 64'h0);
      rd(16'h1BC0, d);
      @(negedge clk);
      rd_en = 1'b1; addr = 16'h1C00;
      #1 check("R1 rdata holds before edge", rdata, 64'h0C00);
      @(posedge clk); #1;
      check("R1 beyond window reads zero", rdata, 64'h0);
      @(negedge clk);
      rd_en = 1'b0;
      rd(16'h17F8, d);   check("R1 below window reads zero", d, 64'h0);
      rd(16'h1820, d);   check("R1 unused slot reads zero", d, 64'h0);
      wr(qa(2, 1), 64'h5000);
      rd(qa(2, 1), d);   check("R1 head slot not writable", d, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_locked();
      t_width();
      t_fifo();
      t_wrap();
      t_collide();
      t_decode();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule